// File: doc/BRIEF.md
# Nibble Shift and Rotate Execution Unit

This unit executes the shift and rotate instruction group of a small 4-bit processor core. Each cycle it may accept one 13-bit instruction word. It decodes the word into one of four operations: logical shift left, logical shift right, rotate left through carry and rotate right through carry. The operand is a 4-bit value taken from accumulator A, from accumulator B, or from a data-memory nibble addressed by one of two 16-bit index registers, X or Y. An indexed form can also increment its index register afterwards.

The unit does not hold A, B, X or Y. It reads their current values on input ports and returns results through write strobes to the core's register file. It holds the carry and zero flags itself. It drives a nibble-wide synchronous memory port, and read data returns in the cycle after the read strobe. Register forms finish in the issue cycle. Memory forms read in the issue cycle and write back in the following cycle, and `busy` is high during that second cycle. A word that is not in the group raises `not_mine` and changes nothing.

Top module: `nib_shift_unit`

## Requirements
- R1: A word is accepted only when bits[12:5] equal 8'b1000_0111 and it is not a register form with bit 3 set. Any other word presented with `op_valid` (while not busy) raises `not_mine` in that same cycle. It produces no register, index or memory strobe, and it leaves the carry and zero flags unchanged.
- R2: A register form has bit 4 = 1 and bit 3 = 0. Bits[1:0] give the operation (00 shift left, 01 shift right, 10 rotate left, 11 rotate right). Bit 2 = 1 writes B through `rf_we_b` and bit 2 = 0 writes A through `rf_we_a`.
- R3: A memory form has bit 4 = 0. Bits[3:2] give the operation with the same coding as R2. Bits[1:0] pick the address: 00 is X, 01 is X with post-increment, 10 is Y, 11 is Y with post-increment.
- R4: Shift left: the new carry is old bit 3, bits 2..0 move up by one, and bit 0 becomes 0.
- R5: Shift right: the new carry is old bit 0, bits 3..1 move down by one, and bit 3 becomes 0.
- R6: Rotate left: the old carry enters bit 0, bits 2..0 move up, and old bit 3 becomes the new carry.
- R7: Rotate right: the old carry enters bit 3, bits 3..1 move down, and old bit 0 becomes the new carry.
- R8: Every accepted operation updates both flags. `flag_z` becomes 1 exactly when the 4-bit result is 0000.
- R9: A register form drives its register write strobe and result in the issue cycle. The flags update at the closing clock edge, and `busy` stays low.
- R10: A memory form raises `mem_rd` with the index address in the issue cycle. In the next cycle `busy` and `mem_wr` are high, the address is the same, and `mem_wdata` carries the result. The flags update at the end of that second cycle.
- R11: A post-increment form raises the matching index write strobe in the write-back cycle, with the address plus one wrapping at 16 bits. The memory write still uses the old address. The forms without increment write no index register.
- R12: `op_valid` is ignored while `busy` is high: no read, no register strobe and no `not_mine`.
- R13: After synchronous reset both flags are 0, `busy` is 0 and no strobe is active while `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_word | input | 13 | Instruction word |
| reg_a | input | 4 | Current value of accumulator A |
| reg_b | input | 4 | Current value of accumulator B |
| idx_x | input | 16 | Current value of index X |
| idx_y | input | 16 | Current value of index Y |
| rf_we_a | output | 1 | Write strobe for A |
| rf_we_b | output | 1 | Write strobe for B |
| rf_wdata | output | 4 | Result for A or B |
| idx_we_x | output | 1 | Write strobe for X |
| idx_we_y | output | 1 | Write strobe for Y |
| idx_wdata | output | 16 | Incremented index value |
| mem_addr | output | 16 | Data-memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| mem_rdata | input | 4 | Memory read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Write-back cycle of a memory form |
| not_mine | output | 1 | Word lies outside this group |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
Strobes, the result and `not_mine` for a register form are combinational in the issue cycle. The bench therefore drives each word on a falling edge and samples them 2 ns later. It reads the flags only after the next falling edge, which follows the single updating rising edge. For memory forms the read address is checked in the issue cycle. The bench returns the read data one cycle later and checks the write-back data, the index increment and the strobes in that second cycle. The flags are checked one falling edge later still, while a junk word is held on the input during the busy cycle.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    localparam int NIB_W   = 4;
    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 13;
    localparam int PFX_W   = 8;
    localparam logic [PFX_W-1:0] GROUP_PFX = 8'b1000_0111;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        ROT_L = 2'd2,
        ROT_R = 2'd3
    } shop_e;

    typedef struct packed {
        logic  mine;
        logic  is_mem;
        logic  sel_b;
        logic  use_y;
        logic  post_inc;
        shop_e op;
    } dec_t;

    typedef struct packed {
        logic             cout;
        logic [NIB_W-1:0] res;
    } sh_res_t;

    function automatic sh_res_t nib_shift(input shop_e op, input logic [NIB_W-1:0] d,
                                          input logic cin);
        sh_res_t r;
        case (op)
            SH_LL:   r = '{cout: d[NIB_W-1], res: {d[NIB_W-2:0], 1'b0}};
            SH_RL:   r = '{cout: d[0],       res: {1'b0, d[NIB_W-1:1]}};
            ROT_L:   r = '{cout: d[NIB_W-1], res: {d[NIB_W-2:0], cin}};
            default: r = '{cout: d[0],       res: {cin, d[NIB_W-1:1]}};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nsr_decode.sv
module nsr_decode
    import nsr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic pfx_ok;
    logic reg_form;

    always_comb begin
        pfx_ok       = (word[WORD_W-1 -: PFX_W] == GROUP_PFX);
        reg_form     = word[4];
        dec.mine     = pfx_ok && !(reg_form && word[3]);
        dec.is_mem   = !reg_form;
        dec.sel_b    = reg_form && word[2];
        dec.use_y    = !reg_form && word[1];
        dec.post_inc = !reg_form && word[0];
        dec.op       = reg_form ? shop_e'(word[1:0]) : shop_e'(word[3:2]);
    end
endmodule

// File: rtl/nsr_alu.sv
module nsr_alu
    import nsr_pkg::*;
(
    input  shop_e            op,
    input  logic [NIB_W-1:0] din,
    input  logic             cin,
    output logic [NIB_W-1:0] dout,
    output logic             cout,
    output logic             zero
);
    sh_res_t r;

    always_comb begin
        r    = nib_shift(op, din, cin);
        dout = r.res;
        cout = r.cout;
        zero = (r.res == '0);
    end
endmodule

// File: rtl/nsr_mem_seq.sv
module nsr_mem_seq
    import nsr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  shop_e         op_in,
    input  logic          use_y_in,
    input  logic          inc_in,
    input  logic [AW-1:0] addr_in,
    output logic          pend,
    output shop_e         op_q,
    output logic          use_y_q,
    output logic          inc_q,
    output logic [AW-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            op_q    <= SH_LL;
            use_y_q <= 1'b0;
            inc_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            pend <= start;
            if (start) begin
                op_q    <= op_in;
                use_y_q <= use_y_in;
                inc_q   <= inc_in;
                addr_q  <= addr_in;
            end
        end
    end
endmodule

// File: rtl/nib_shift_unit.sv
module nib_shift_unit
    import nsr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    input  logic [NIB_W-1:0]  reg_a,
    input  logic [NIB_W-1:0]  reg_b,
    input  logic [AW-1:0]     idx_x,
    input  logic [AW-1:0]     idx_y,
    output logic              rf_we_a,
    output logic              rf_we_b,
    output logic [NIB_W-1:0]  rf_wdata,
    output logic              idx_we_x,
    output logic              idx_we_y,
    output logic [AW-1:0]     idx_wdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [NIB_W-1:0]  mem_wdata,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              busy,
    output logic              not_mine,
    output logic              flag_c,
    output logic              flag_z
);
    dec_t             dec;
    logic             accept;
    logic             exec_reg;
    logic             issue_mem;
    shop_e            op_q;
    logic             use_y_q;
    logic             inc_q;
    logic [AW-1:0]    addr_q;
    logic [AW-1:0]    issue_addr;
    shop_e            alu_op;
    logic [NIB_W-1:0] alu_in;
    logic [NIB_W-1:0] alu_out;
    logic             alu_c;
    logic             alu_z;

    nsr_decode u_dec (
        .word (op_word),
        .dec  (dec)
    );

    always_comb begin
        accept     = op_valid && !busy;
        not_mine   = accept && !dec.mine;
        exec_reg   = accept && dec.mine && !dec.is_mem;
        issue_mem  = accept && dec.mine && dec.is_mem;
        issue_addr = dec.use_y ? idx_y : idx_x;
    end

    nsr_mem_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (issue_mem),
        .op_in    (dec.op),
        .use_y_in (dec.use_y),
        .inc_in   (dec.post_inc),
        .addr_in  (issue_addr),
        .pend     (busy),
        .op_q     (op_q),
        .use_y_q  (use_y_q),
        .inc_q    (inc_q),
        .addr_q   (addr_q)
    );

    always_comb begin
        alu_op = busy ? op_q : dec.op;
        if (busy)
            alu_in = mem_rdata;
        else
            alu_in = dec.sel_b ? reg_b : reg_a;
    end

    nsr_alu u_alu (
        .op   (alu_op),
        .din  (alu_in),
        .cin  (flag_c),
        .dout (alu_out),
        .cout (alu_c),
        .zero (alu_z)
    );

    always_comb begin
        rf_we_a   = exec_reg && !dec.sel_b;
        rf_we_b   = exec_reg && dec.sel_b;
        rf_wdata  = alu_out;
        mem_rd    = issue_mem;
        mem_wr    = busy;
        mem_addr  = busy ? addr_q : issue_addr;
        mem_wdata = alu_out;
        idx_we_x  = busy && inc_q && !use_y_q;
        idx_we_y  = busy && inc_q && use_y_q;
        idx_wdata = addr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else if (exec_reg || busy) begin
            flag_c <= alu_c;
            flag_z <= alu_z;
        end
    end
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          not_mine,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_wdata,
    input logic          rf_we_a,
    input logic          rf_we_b,
    input logic [3:0]    rf_wdata,
    input logic          idx_we_x,
    input logic          idx_we_y,
    input logic [AW-1:0] idx_wdata,
    input logic          flag_c,
    input logic          flag_z
);
    a_r13_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !flag_c && !flag_z));

    a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
        not_mine |-> (!mem_rd && !rf_we_a && !rf_we_b && !idx_we_x && !idx_we_y));

    a_r1_foreign_flags: assert property (@(posedge clk) disable iff (rst)
        not_mine |=> ($stable(flag_c) && $stable(flag_z)));

    a_r10_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_wr && busy));

    a_r10_same_address: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_addr == $past(mem_addr)));

    a_r9_reg_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (rf_we_a || rf_we_b) |-> (!busy && !mem_rd && !mem_wr));

    a_r9_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_we_a, rf_we_b, mem_wr}));

    a_r11_increment: assert property (@(posedge clk) disable iff (rst)
        (idx_we_x || idx_we_y) |-> (mem_wr && idx_wdata == mem_addr + AW'(1)));

    a_r11_one_index: assert property (@(posedge clk) disable iff (rst)
        $onehot0({idx_we_x, idx_we_y}));

    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (rf_we_a || rf_we_b) |=> (flag_z == ($past(rf_wdata) == 4'd0)));

    a_r8_zero_mem: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (flag_z == ($past(mem_wdata) == 4'd0)));

    a_r12_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!mem_rd && !not_mine && !rf_we_a && !rf_we_b));
endmodule

bind nib_shift_unit nsr_checker #(.AW(AW)) u_nsr_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .not_mine  (not_mine),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_we_a   (rf_we_a),
    .rf_we_b   (rf_we_b),
    .rf_wdata  (rf_wdata),
    .idx_we_x  (idx_we_x),
    .idx_we_y  (idx_we_y),
    .idx_wdata (idx_wdata),
    .flag_c    (flag_c),
    .flag_z    (flag_z)
);

// File: tb/tb_nib_shift_unit.sv
module tb_nib_shift_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [12:0] op_word = '0;
    logic [3:0]  m_a = '0;
    logic [3:0]  m_b = '0;
    logic [15:0] m_x = '0;
    logic [15:0] m_y = '0;
    logic [3:0]  mem_rdata = '0;
    logic        rf_we_a, rf_we_b, idx_we_x, idx_we_y;
    logic [3:0]  rf_wdata, mem_wdata;
    logic [15:0] idx_wdata, mem_addr;
    logic        mem_rd, mem_wr, busy, not_mine, flag_c, flag_z;

    logic [3:0]  mem_m [0:255];
    logic        exp_c = 1'b0;
    logic        exp_z = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    nib_shift_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word),
        .reg_a(m_a), .reg_b(m_b), .idx_x(m_x), .idx_y(m_y),
        .rf_we_a(rf_we_a), .rf_we_b(rf_we_b), .rf_wdata(rf_wdata),
        .idx_we_x(idx_we_x), .idx_we_y(idx_we_y), .idx_wdata(idx_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .not_mine(not_mine), .flag_c(flag_c), .flag_z(flag_z)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] ref_shift(input logic [1:0] op, input logic [3:0] d,
                                             input logic c);
        case (op)
            2'd0:    return {d[3], d[2], d[1], d[0], 1'b0};
            2'd1:    return {d[0], 1'b0, d[3], d[2], d[1]};
            2'd2:    return {d[3], d[2], d[1], d[0], c};
            default: return {d[0], c, d[3], d[2], d[1]};
        endcase
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R4 shift-left";
            2'd1:    return "R5 shift-right";
            2'd2:    return "R6 rotate-left";
            default: return "R7 rotate-right";
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic check_flags(input string tag);
        chk(flag_c == exp_c, {tag, " carry"}, 32'(flag_c), 32'(exp_c));
        chk(flag_z == exp_z, {"R8 zero after ", tag}, 32'(flag_z), 32'(exp_z));
    endtask

    task automatic do_op(input logic [12:0] w);
        bit          legal;
        logic [1:0]  op;
        logic [3:0]  d;
        logic [4:0]  r;
        logic [15:0] ad;
        bit          usey, inc, wa, wb, wx, wy;
        logic [3:0]  wdat;
        logic [15:0] iw;
        legal = (w[12:5] == 8'b1000_0111) && !(w[4] && w[3]);
        @(negedge clk);
        op_valid = 1'b1;
        op_word  = w;
        #2;
        if (!legal) begin
            chk(not_mine == 1'b1, "R1 not_mine", 32'(not_mine), 1);
            chk(!(mem_rd || rf_we_a || rf_we_b || idx_we_x || idx_we_y),
                "R1 no strobe", {27'd0, mem_rd, rf_we_a, rf_we_b, idx_we_x, idx_we_y}, 0);
            @(negedge clk);
            op_valid = 1'b0;
            #2;
            check_flags("R1 foreign word kept flags");
            chk(busy == 1'b0, "R1 not busy", 32'(busy), 0);
        end else if (w[4]) begin
            op = w[1:0];
            d  = w[2] ? m_b : m_a;
            r  = ref_shift(op, d, exp_c);
            chk(not_mine == 1'b0, "R2 accepted", 32'(not_mine), 0);
            chk(rf_we_a == !w[2] && rf_we_b == w[2], "R2 target select",
                {30'd0, rf_we_b, rf_we_a}, w[2] ? 2 : 1);
            chk(rf_wdata == r[3:0], op_tag(op), 32'(rf_wdata), 32'(r[3:0]));
            chk(!busy && !mem_rd && !mem_wr, "R9 single cycle",
                {29'd0, busy, mem_rd, mem_wr}, 0);
            wa = rf_we_a; wb = rf_we_b; wdat = rf_wdata;
            @(negedge clk);
            op_valid = 1'b0;
            if (wa) m_a = wdat;
            if (wb) m_b = wdat;
            exp_c = r[4];
            exp_z = (r[3:0] == 4'd0);
            #2;
            check_flags(op_tag(op));
            chk(busy == 1'b0, "R9 busy low", 32'(busy), 0);
        end else begin
            op   = w[3:2];
            usey = w[1];
            inc  = w[0];
            ad   = usey ? m_y : m_x;
            chk(mem_rd == 1'b1, "R10 read in issue cycle", 32'(mem_rd), 1);
            chk(mem_addr == ad, "R3 address select", 32'(mem_addr), 32'(ad));
            chk(!rf_we_a && !rf_we_b && !not_mine, "R3 memory form only",
                {29'd0, rf_we_a, rf_we_b, not_mine}, 0);
            @(negedge clk);
            mem_rdata = mem_m[ad[7:0]];
            op_valid  = 1'b1;
            op_word   = {8'b1000_0111, 2'b10, 3'($urandom)};
            d = mem_rdata;
            r = ref_shift(op, d, exp_c);
            #2;
            chk(busy && mem_wr, "R10 write-back cycle", {30'd0, busy, mem_wr}, 3);
            chk(mem_addr == ad, "R11 write uses old address", 32'(mem_addr), 32'(ad));
            chk(mem_wdata == r[3:0], op_tag(op), 32'(mem_wdata), 32'(r[3:0]));
            chk(!mem_rd && !not_mine && !rf_we_a && !rf_we_b, "R12 ignored while busy",
                {28'd0, mem_rd, not_mine, rf_we_a, rf_we_b}, 0);
            chk(idx_we_x == (inc && !usey) && idx_we_y == (inc && usey), "R11 index strobe",
                {30'd0, idx_we_y, idx_we_x}, {30'd0, inc && usey, inc && !usey});
            if (inc)
                chk(idx_wdata == ad + 16'd1, "R11 wrapped increment",
                    32'(idx_wdata), 32'(ad + 16'd1));
            wx = idx_we_x; wy = idx_we_y; iw = idx_wdata; wdat = mem_wdata;
            @(negedge clk);
            op_valid = 1'b0;
            mem_m[ad[7:0]] = wdat;
            if (wx) m_x = iw;
            if (wy) m_y = iw;
            exp_c = r[4];
            exp_z = (r[3:0] == 4'd0);
            #2;
            check_flags({"R10 ", op_tag(op)});
            chk(busy == 1'b0 && mem_wr == 1'b0, "R10 back to idle",
                {30'd0, busy, mem_wr}, 0);
        end
    endtask

    function automatic logic [12:0] pick_word();
        int k;
        k = int'($urandom % 10);
        if (k < 2)
            return {8'b1000_0111, 5'($urandom)};
        else if (k < 3)
            return 13'($urandom);
        else if (k < 6)
            return {8'b1000_0111, 2'b10, 3'($urandom)};
        else
            return {8'b1000_0111, 1'b0, 4'($urandom)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) mem_m[i] = 4'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R13 reset state
        chk(flag_c == 0 && flag_z == 0, "R13 flags cleared", {30'd0, flag_c, flag_z}, 0);
        chk(!busy && !mem_rd && !mem_wr && !rf_we_a && !rf_we_b && !not_mine,
            "R13 idle", {26'd0, busy, mem_rd, mem_wr, rf_we_a, rf_we_b, not_mine}, 0);

        // Directed corner cases
        m_a = 4'b1001;
        do_op(13'b1_0000_1111_0000);      // shift left A: carry 1, A=0010
        chk(m_a == 4'b0010, "R4 A result", 32'(m_a), 32'b0010);
        m_b = 4'b0001;
        do_op(13'b1_0000_1111_0101);      // shift right B: result zero
        chk(m_b == 4'd0, "R5 B to zero", 32'(m_b), 0);
        m_a = 4'b1000;
        do_op(13'b1_0000_1111_0010);      // rotate left A with carry in 1
        chk(m_a == 4'b0001, "R6 carry enters bit0", 32'(m_a), 1);
        m_b = 4'b0001;
        do_op(13'b1_0000_1111_0111);      // rotate right B with carry in 1
        chk(m_b == 4'b1000, "R7 carry enters bit3", 32'(m_b), 8);
        do_op(13'b1_0000_1111_1000);      // bit3 set on register form: foreign
        do_op(13'b0_1111_0000_0000);      // wrong prefix
        m_x = 16'hFFFF;
        do_op(13'b1_0000_1110_0001);      // shift left [X] then X+1 wraps
        chk(m_x == 16'h0000, "R11 X wraps to zero", 32'(m_x), 0);
        m_y = 16'h1234;
        do_op(13'b1_0000_1110_1110);      // rotate right [Y], no increment
        chk(m_y == 16'h1234, "R11 Y unchanged", 32'(m_y), 32'h1234);
        do_op(13'b1_0000_1110_0111);      // shift right [Y]+
        chk(m_y == 16'h1235, "R11 Y incremented", 32'(m_y), 32'h1235);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            if (n % 16 == 0) begin
                m_a = 4'($urandom);
                m_b = 4'($urandom);
                m_x = 16'($urandom);
                m_y = (n % 32 == 0) ? 16'hFFFF : 16'($urandom);
            end
            do_op(pick_word());
        end

        @(negedge clk);
        finish_run();
    end
endmodule